// File: doc/BRIEF.md
# Pipelined Graphics-Port Request Sequencer

This block is the bus-master side of a pipelined graphics port. An internal client hands it read and write requests. Each request has a two-bit command that gives the direction and the priority, a 32-bit address and a tag. The block holds them in a small pending queue. When the arbiter grants the bus with the start code, the block places the oldest request's address on the shared address/data bus and pulls the active-low pipe strobe. It enqueues at most one request per clock.

Every request that has been enqueued waits in one of four in-order outstanding queues, one for each direction/priority pair. Later the arbiter's three-bit status code chooses which queue's head is served. A read return is passed to the client with its tag and the data word sampled from the bus. A write data phase is passed to the client as a strobe with the tag of the write to be supplied.

An active-low read-buffer-full output stops the arbiter from returning low-priority reads. Any data phase that makes no sense raises a one-cycle error pulse.

Top module: `agp_req_seq`

## Requirements
- R1: While `gnt_n` is high, `st` is ignored. Nothing is enqueued, no data phase is reported and no error is raised.
- R2: Command encoding: `cmd[1]`=1 is a write and `cmd[0]`=1 is high priority. Status 000 (low priority) and status 001 (high priority) under grant are read returns. One cycle later `rd_valid`=1, `rd_hi`=`st[0]`, `rd_tag` is the oldest outstanding read tag of that priority and `rd_data` is the `ad_in` value sampled in the status cycle.
- R3: Status 010 and status 011 under grant are write data phases. One cycle later `wr_go`=1, `wr_hi`=`st[0]` and `wr_tag` is the oldest outstanding write tag of that priority.
- R4: Status codes 100, 101 and 110 do nothing.
- R5: In a cycle with grant and status 111, with a request pending and fewer than OUTS_MAX outstanding, the next cycle has `pipe_n`=0 and `ad_oe`=1. `ad_out` then holds the address of the oldest pending request, and that request is enqueued.
- R6: `pipe_n` returns high and `ad_oe` low in the cycle after a cycle in which the pending queue was empty, grant was removed or the status was not 111.
- R7: No more than OUTS_MAX requests are outstanding at any time. When the limit is reached, enqueueing stops until a data phase retires an entry.
- R8: `rbf_n` equals the inverse of `lpbuf_full` from the previous cycle.
- R9: `err` pulses one cycle after a data-phase status (000 to 011) under grant whose queue is empty. It also pulses one cycle after status 000 under grant while `rbf_n` is low. In that second case the return is still delivered.
- R10: While `rst_n` is low: `pipe_n`=1, `ad_oe`=0 (bus released), `rbf_n`=1, and `rd_valid`, `wr_go` and `err` are all 0.
- R11: `req_ready` is low exactly when REQ_DEPTH requests are pending. A request is taken when `req_valid` and `req_ready` are both high.
- R12: Each of the four outstanding queues serves its entries in the order in which they were enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a request |
| req_cmd | input | 2 | Bit 1 write, bit 0 high priority |
| req_addr | input | 32 | Request address |
| req_tag | input | TAG_W | Client tag carried with the request |
| req_ready | output | 1 | Pending queue has room |
| gnt_n | input | 1 | Active-low grant from the arbiter |
| st | input | 3 | Arbiter status code |
| ad_in | input | 32 | Bus value, read data in return cycles |
| ad_out | output | 32 | Request address driven on the bus |
| ad_oe | output | 1 | Bus drive enable |
| pipe_n | output | 1 | Active-low pipe strobe |
| lpbuf_full | input | 1 | Client low-priority return buffer is full |
| rbf_n | output | 1 | Active-low read-buffer-full to the arbiter |
| rd_valid | output | 1 | Read return valid |
| rd_hi | output | 1 | Read return is high priority |
| rd_tag | output | TAG_W | Tag of the returned read |
| rd_data | output | 32 | Returned data word |
| wr_go | output | 1 | Client must supply write data now |
| wr_hi | output | 1 | Write phase is high priority |
| wr_tag | output | TAG_W | Tag of the write being served |
| err | output | 1 | Protocol error pulse |

## Verification
Every result is due exactly one rising edge after the cycle whose inputs cause it. This covers the pipe strobe with its address, read returns, write strobes, the error pulse and `rbf_n`. `req_ready` depends only on state and is valid before the edge. The bench applies inputs at the falling edge and works out the expected post-edge values from its own queue model. It checks `req_ready` shortly after driving the inputs and the registered outputs at the next falling edge, so each result is compared in the one cycle where it is due.

// File: rtl/agp_seq_pkg.sv
package agp_seq_pkg;
  localparam int ADDR_W = 32;
  localparam int NQ     = 4;   // queue index = {write, high}

  localparam logic [2:0] ST_GO = 3'b111;

  // Status codes 0xx are data phases; low two bits pick the queue.
  function automatic logic is_phase(logic [2:0] s);
    return ~s[2];
  endfunction

  function automatic logic is_go(logic [2:0] s);
    return s == ST_GO;
  endfunction

  function automatic logic [1:0] phase_queue(logic [2:0] s);
    return s[1:0];
  endfunction

  // Outstanding counter step: issue and retire never coincide.
  function automatic int unsigned next_level(int unsigned lvl, logic inc, logic dec);
    return lvl + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction
endpackage

// File: rtl/agp_fifo.sv
module agp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/agp_status_dec.sv
module agp_status_dec
  import agp_seq_pkg::*;
(
  input  logic       gnt_n,
  input  logic [2:0] st,
  output logic       phase_v,
  output logic [1:0] phase_q,
  output logic       go
);
  assign phase_v = ~gnt_n & is_phase(st);
  assign phase_q = phase_queue(st);
  assign go      = ~gnt_n & is_go(st);
endmodule

// File: rtl/agp_req_seq.sv
module agp_req_seq
  import agp_seq_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int REQ_DEPTH = 4,
  parameter int OUTS_MAX  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [31:0]       req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_ready,
  input  logic              gnt_n,
  input  logic [2:0]        st,
  input  logic [31:0]       ad_in,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  output logic              pipe_n,
  input  logic              lpbuf_full,
  output logic              rbf_n,
  output logic              rd_valid,
  output logic              rd_hi,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [31:0]       rd_data,
  output logic              wr_go,
  output logic              wr_hi,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              err
);
  localparam int PW = 2 + TAG_W + ADDR_W;
  localparam int CW = $clog2(OUTS_MAX + 1);

  // decoded events, named for the checker
  logic          phase_v, go;
  logic [1:0]    phase_q;
  logic          issue, hit, miss, rbf_viol;
  logic          pend_empty, pend_full;
  logic [PW-1:0] pend_dout;
  logic [1:0]    issue_q;
  logic [CW-1:0] outs_cnt;
  logic [31:0]   outs_level;
  logic [NQ-1:0] oq_empty;
  logic [TAG_W-1:0] oq_dout [NQ];

  agp_status_dec u_dec (
    .gnt_n   (gnt_n),
    .st      (st),
    .phase_v (phase_v),
    .phase_q (phase_q),
    .go      (go)
  );

  assign req_ready = ~pend_full;

  agp_fifo #(.W(PW), .DEPTH(REQ_DEPTH)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid & ~pend_full),
    .din   ({req_cmd, req_tag, req_addr}),
    .pop   (issue),
    .dout  (pend_dout),
    .empty (pend_empty),
    .full  (pend_full)
  );

  assign issue_q    = pend_dout[PW-1 -: 2];
  assign issue      = go & ~pend_empty & (outs_cnt < CW'(OUTS_MAX));
  assign hit        = phase_v & ~oq_empty[phase_q];
  assign miss       = phase_v & oq_empty[phase_q];
  assign rbf_viol   = phase_v & (phase_q == 2'b00) & ~rbf_n;
  assign outs_level = 32'(outs_cnt);

  for (genvar q = 0; q < NQ; q++) begin : g_oq
    logic oq_full_unused;
    agp_fifo #(.W(TAG_W), .DEPTH(OUTS_MAX)) u_oq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (issue & (issue_q == 2'(q))),
      .din   (pend_dout[ADDR_W +: TAG_W]),
      .pop   (hit & (phase_q == 2'(q))),
      .dout  (oq_dout[q]),
      .empty (oq_empty[q]),
      .full  (oq_full_unused)
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_n   <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      rbf_n    <= 1'b1;
      rd_valid <= 1'b0;
      rd_hi    <= 1'b0;
      rd_tag   <= '0;
      rd_data  <= '0;
      wr_go    <= 1'b0;
      wr_hi    <= 1'b0;
      wr_tag   <= '0;
      err      <= 1'b0;
      outs_cnt <= '0;
    end else begin
      pipe_n   <= ~issue;
      ad_oe    <= issue;
      if (issue) ad_out <= pend_dout[ADDR_W-1:0];
      rbf_n    <= ~lpbuf_full;
      rd_valid <= hit & ~phase_q[1];
      wr_go    <= hit & phase_q[1];
      if (hit & ~phase_q[1]) begin
        rd_hi   <= phase_q[0];
        rd_tag  <= oq_dout[phase_q];
        rd_data <= ad_in;
      end
      if (hit & phase_q[1]) begin
        wr_hi  <= phase_q[0];
        wr_tag <= oq_dout[phase_q];
      end
      err      <= miss | rbf_viol;
      outs_cnt <= CW'(next_level(int'(outs_cnt), issue, hit));
    end
  end
endmodule

// File: rtl/agp_req_seq_chk.sv
module agp_req_seq_chk #(
  parameter int LIMIT = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        gnt_n,
  input logic [2:0]  st,
  input logic        pipe_n,
  input logic        ad_oe,
  input logic        rd_valid,
  input logic        wr_go,
  input logic        rbf_n,
  input logic        lpbuf_full,
  input logic        err,
  input logic        pend_empty,
  input logic [31:0] outs_level
);
  a_r5_pipe_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_n |-> ($past(!gnt_n && st == 3'b111) && ad_oe));

  a_r6_pipe_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_n |-> $past(!pend_empty));

  a_r1_no_phase_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_go) |-> $past(!gnt_n));

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!gnt_n && st[2]) |-> !(rd_valid || wr_go));

  a_r7_limit: assert property (@(posedge clk) disable iff (!rst_n)
    outs_level <= 32'(LIMIT));

  a_r8_rbf_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rbf_n == $past(!lpbuf_full));

  a_r9_rbf_violation: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!gnt_n && st == 3'b000 && !rbf_n) |-> err);
endmodule

bind agp_req_seq agp_req_seq_chk #(.LIMIT(OUTS_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gnt_n      (gnt_n),
  .st         (st),
  .pipe_n     (pipe_n),
  .ad_oe      (ad_oe),
  .rd_valid   (rd_valid),
  .wr_go      (wr_go),
  .rbf_n      (rbf_n),
  .lpbuf_full (lpbuf_full),
  .err        (err),
  .pend_empty (pend_empty),
  .outs_level (outs_level)
);

// File: tb/agp_req_seq_test.sv
`timescale 1ns/1ps
module agp_req_seq_test;
  localparam int TAG_W = 4, REQ_DEPTH = 4, OUTS_MAX = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready;
  logic gnt_n = 1'b1;
  logic [2:0] st = 3'b100;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic ad_oe, pipe_n, lpbuf_full = 1'b0, rbf_n;
  logic rd_valid, rd_hi, wr_go, wr_hi, err;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  agp_req_seq #(.TAG_W(TAG_W), .REQ_DEPTH(REQ_DEPTH), .OUTS_MAX(OUTS_MAX)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [37:0] pq[$];              // {cmd, tag, addr}
  logic [3:0] oq0[$], oq1[$], oq2[$], oq3[$];
  int cnt = 0;
  logic m_rbf_n = 1'b1;
  logic [3:0] tag_ctr = '0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int oq_size(input logic [1:0] q);
    case (q)
      2'd0: return oq0.size();
      2'd1: return oq1.size();
      2'd2: return oq2.size();
      default: return oq3.size();
    endcase
  endfunction

  function automatic logic [3:0] oq_pop(input logic [1:0] q);
    case (q)
      2'd0: return oq0.pop_front();
      2'd1: return oq1.pop_front();
      2'd2: return oq2.pop_front();
      default: return oq3.pop_front();
    endcase
  endfunction

  function automatic void oq_push(input logic [1:0] q, input logic [3:0] t);
    case (q)
      2'd0: oq0.push_back(t);
      2'd1: oq1.push_back(t);
      2'd2: oq2.push_back(t);
      default: oq3.push_back(t);
    endcase
  endfunction

  // one cycle: called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic v, input logic [1:0] cmd, input logic [31:0] a,
                     input logic g_n, input logic [2:0] s, input logic [31:0] din,
                     input logic full);
    logic ready_pre, e_issue, e_rd, e_wr, e_err, e_hi;
    logic [31:0] e_ad;
    logic [3:0] e_tag;
    logic [37:0] head;
    req_valid = v; req_cmd = cmd; req_addr = a; req_tag = tag_ctr;
    gnt_n = g_n; st = s; ad_in = din; lpbuf_full = full;
    #1;
    ready_pre = (pq.size() < REQ_DEPTH);
    chk(req_ready === ready_pre, "R11 req_ready", 32'(req_ready), 32'(ready_pre));
    e_issue = 0; e_rd = 0; e_wr = 0; e_err = 0; e_hi = 0; e_ad = '0; e_tag = '0;
    if (!g_n && s == 3'b111 && pq.size() > 0 && cnt < OUTS_MAX) begin
      e_issue = 1;
      head = pq.pop_front();
      e_ad = head[31:0];
      oq_push(head[37:36], head[35:32]);
      cnt++;
    end
    if (!g_n && !s[2]) begin
      if (oq_size(s[1:0]) > 0) begin
        e_tag = oq_pop(s[1:0]);
        cnt--;
        e_hi = s[0];
        if (s[1]) e_wr = 1; else e_rd = 1;
      end else e_err = 1;
      if (s == 3'b000 && !m_rbf_n) e_err = 1;
    end
    m_rbf_n = !full;
    if (v && ready_pre) begin
      pq.push_back({cmd, tag_ctr, a});
      tag_ctr = tag_ctr + 1'b1;
    end
    @(posedge clk); @(negedge clk);
    chk(pipe_n === !e_issue, "R5/R6 pipe_n", 32'(pipe_n), 32'(!e_issue));
    chk(ad_oe === e_issue, "R5/R6 ad_oe", 32'(ad_oe), 32'(e_issue));
    if (e_issue) chk(ad_out === e_ad, "R5 ad_out", ad_out, e_ad);
    chk(rbf_n === m_rbf_n, "R8 rbf_n", 32'(rbf_n), 32'(m_rbf_n));
    chk(err === e_err, "R9 err", 32'(err), 32'(e_err));
    chk(rd_valid === e_rd, "R2 rd_valid", 32'(rd_valid), 32'(e_rd));
    chk(wr_go === e_wr, "R3 wr_go", 32'(wr_go), 32'(e_wr));
    if (e_rd) begin
      chk(rd_tag === e_tag, "R12 rd_tag", 32'(rd_tag), 32'(e_tag));
      chk(rd_hi === e_hi, "R2 rd_hi", 32'(rd_hi), 32'(e_hi));
      chk(rd_data === din, "R2 rd_data", rd_data, din);
    end
    if (e_wr) begin
      chk(wr_tag === e_tag, "R12 wr_tag", 32'(wr_tag), 32'(e_tag));
      chk(wr_hi === e_hi, "R3 wr_hi", 32'(wr_hi), 32'(e_hi));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(pipe_n === 1'b1 && ad_oe === 1'b0, "R10 bus released", {pipe_n, ad_oe}, 32'h2);
    chk(rbf_n === 1'b1 && rd_valid === 1'b0 && wr_go === 1'b0 && err === 1'b0,
        "R10 idle outputs", {rbf_n, rd_valid, wr_go, err}, 32'h8);
    chk(req_ready === 1'b1, "R10 req_ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: fill the pending queue with no grant; R1: go status ignored without grant
    for (int i = 0; i < REQ_DEPTH + 2; i++)
      cyc(1'b1, 2'(i), 32'h1000_0000 + 32'(i), 1'b1, 3'b111, '0, 1'b0);
    // R1: data-phase codes without grant
    for (int i = 0; i < 4; i++)
      cyc(1'b0, '0, '0, 1'b1, 3'(i), 32'hdead_0000, 1'b0);
    // R4: reserved codes under grant
    for (int i = 4; i < 7; i++)
      cyc(1'b0, '0, '0, 1'b0, 3'(i), '0, 1'b0);
    // R5/R7: keep pushing low-priority reads under go until the limit stalls issue
    for (int i = 0; i < 12; i++)
      cyc(1'b1, 2'b00, 32'h2000_0000 + 32'(i), 1'b0, 3'b111, '0, 1'b0);
    // R6: grant removed
    cyc(1'b0, '0, '0, 1'b1, 3'b111, '0, 1'b0);
    // R9: low-priority return while rbf_n low (set full, then return)
    cyc(1'b0, '0, '0, 1'b1, 3'b100, '0, 1'b1);
    cyc(1'b0, '0, '0, 1'b0, 3'b000, 32'hcafe_0001, 1'b1);
    cyc(1'b0, '0, '0, 1'b0, 3'b000, 32'hcafe_0002, 1'b0);
    // R2/R3/R12: drain every queue, including empty-queue errors
    for (int i = 0; i < 16; i++)
      cyc(1'b0, '0, '0, 1'b0, 3'(i % 4), 32'h3000_0000 + 32'(i), 1'b0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] s;
      int r = $urandom_range(0, 99);
      s = (r < 35) ? 3'b111 : 3'($urandom_range(0, 6));
      cyc(($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)), $urandom(),
          ($urandom_range(0, 3) == 0), s, $urandom(), ($urandom_range(0, 4) == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule